// File: doc/BRIEF.md
# Omega Multistage Switching Network

This block moves up to N data words from N input ports to N output ports through a multistage network of 2x2 switching elements. N is a power of two. The network has log2(N) stages of N/2 elements, and a fixed perfect-shuffle wiring sits in front of every stage. The path from the inputs to the outputs is combinational. One register stage captures the result, so every output appears one clock after its inputs.

There are two ways to control the network. In self-routing mode, each valid input carries the number of its destination port, and every element steers the word using one bit of that number. When two words at one element need the same element output, the element keeps the upper word, discards the lower one and raises a blocked flag for the discarded word's source port. In explicit mode, a 2-bit setting for each element picks straight, cross, upper broadcast or lower broadcast, and the destination numbers are ignored. In this mode the network can fan one input out to several outputs.

Top module: `omega_net`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_data` and `blocked` are all zero after that edge.
- R2: Outputs are registered. The result for the inputs present before a rising edge appears after that edge and is held until the next edge.
- R3: In self-routing mode (`self_route`=1), stage i (0 = first) steers by destination bit log2(N)-1-i, where 0 selects the upper element output and 1 the lower. A valid word that meets no conflict arrives at output port `in_dest` of its source, carrying its data, with that port's `out_valid` set.
- R4: In self-routing mode, when both inputs of an element are valid and need the same output, the upper word proceeds and the lower word is dropped. Bit s of `blocked` is then 1, where s is the dropped word's source port. Only the word that reaches the contested element first is affected.
- R5: In explicit mode (`self_route`=0), setting 2'b00 passes upper to upper and lower to lower, and 2'b01 swaps them. The setting of element e (0 = top) in stage s sits at `sw_cfg[(s*N/2+e)*2 +: 2]`.
- R6: In explicit mode, setting 2'b10 copies the upper input to both outputs, and 2'b11 copies the lower input to both outputs. The input that is not copied is discarded without a flag.
- R7: In explicit mode, `blocked` is all zero and `in_dest` has no effect on the outputs.
- R8: Output line a of each stage feeds input line rotl(a) of the next stage, where rotl moves the top address bit to the least significant position. As a result, with every element set straight, input i appears at output i.
- R9: An input with `in_valid` low reaches no output and is never flagged. An output whose `out_valid` is low shows zero data.
- R10: In self-routing mode, `sw_cfg` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| self_route | input | 1 | 1 = destination-tag routing, 0 = explicit element settings |
| in_valid | input | N_PORTS | Valid flag per input port |
| in_data | input | N_PORTS*DATA_W | Data per input port; port i at [i*DATA_W +: DATA_W] |
| in_dest | input | N_PORTS*log2(N_PORTS) | Destination port per input; port i at [i*log2(N) +: log2(N)] |
| sw_cfg | input | log2(N_PORTS)*N_PORTS | 2-bit setting per element, stage-major |
| out_valid | output | N_PORTS | Registered valid per output port |
| out_data | output | N_PORTS*DATA_W | Registered data per output port |
| blocked | output | N_PORTS | Registered flag per input port whose word was dropped by a conflict |

## Verification
Four kinds of stimulus drive the bench model each cycle. Random full permutations in self-routing mode show which orderings pass cleanly and which lose words, so they exercise the bit order used at each stage. Random destinations that contain deliberate duplicates force the conflict rule, and a hand-built clash between ports 0 and 4 pins down which word wins and which source is flagged. In explicit mode, uniform straight, cross and broadcast settings, followed by random per-element settings, separate the four element codes and check the shuffle wiring. Patterns with idle inputs and junk payloads, and self-routing runs with random settings applied, show that invalid words and unused controls leave no trace.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // 2-bit element setting used in explicit mode
  typedef enum logic [1:0] {
    SW_STRAIGHT = 2'b00,
    SW_CROSS    = 2'b01,
    SW_BC_UPPER = 2'b10,
    SW_BC_LOWER = 2'b11
  } sw_set_e;

  // Rotate a line address left by one bit within 'bits' bits
  function automatic int unsigned rotl_line(input int unsigned a, input int unsigned bits);
    int unsigned mask;
    mask = (32'd1 << bits) - 32'd1;
    return ((a << 1) | (a >> (bits - 1))) & mask;
  endfunction

endpackage

// File: rtl/omega_shuffle.sv
module omega_shuffle #(
  parameter int N_LINES = 8,
  parameter int PAY_W   = 8
) (
  input  logic [N_LINES-1:0]            v_i,
  input  logic [N_LINES-1:0][PAY_W-1:0] p_i,
  output logic [N_LINES-1:0]            v_o,
  output logic [N_LINES-1:0][PAY_W-1:0] p_o
);
  localparam int LG = $clog2(N_LINES);

  for (genvar a = 0; a < N_LINES; a++) begin : g_wire
    localparam int DST = int'(omega_pkg::rotl_line(a, LG));
    assign v_o[DST] = v_i[a];
    assign p_o[DST] = p_i[a];
  end
endmodule

// File: rtl/omega_switch.sv
module omega_switch #(
  parameter int PAY_W = 8
) (
  input  logic             self_mode,
  input  logic [1:0]       setting,
  input  logic             up_v,
  input  logic [PAY_W-1:0] up_p,
  input  logic             up_bit,
  input  logic             lo_v,
  input  logic [PAY_W-1:0] lo_p,
  input  logic             lo_bit,
  output logic             o_up_v,
  output logic [PAY_W-1:0] o_up_p,
  output logic             o_lo_v,
  output logic [PAY_W-1:0] o_lo_p,
  output logic             lo_drop
);
  import omega_pkg::*;

  logic clash;
  assign clash = up_v && lo_v && (up_bit == lo_bit);

  always_comb begin
    o_up_v  = 1'b0;
    o_lo_v  = 1'b0;
    o_up_p  = '0;
    o_lo_p  = '0;
    lo_drop = 1'b0;
    if (self_mode) begin
      if (up_v) begin
        if (up_bit) begin
          o_lo_v = 1'b1;
          o_lo_p = up_p;
        end else begin
          o_up_v = 1'b1;
          o_up_p = up_p;
        end
      end
      if (lo_v && !clash) begin
        if (lo_bit) begin
          o_lo_v = 1'b1;
          o_lo_p = lo_p;
        end else begin
          o_up_v = 1'b1;
          o_up_p = lo_p;
        end
      end
      lo_drop = clash;
    end else begin
      case (sw_set_e'(setting))
        SW_STRAIGHT: begin
          o_up_v = up_v; o_up_p = up_p;
          o_lo_v = lo_v; o_lo_p = lo_p;
        end
        SW_CROSS: begin
          o_up_v = lo_v; o_up_p = lo_p;
          o_lo_v = up_v; o_lo_p = up_p;
        end
        SW_BC_UPPER: begin
          o_up_v = up_v; o_up_p = up_p;
          o_lo_v = up_v; o_lo_p = up_p;
        end
        default: begin
          o_up_v = lo_v; o_up_p = lo_p;
          o_lo_v = lo_v; o_lo_p = lo_p;
        end
      endcase
    end
  end
endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int N_LINES  = 8,
  parameter int PAY_W    = 14,
  parameter int SRC_W    = 3,
  parameter int STEER_AT = 3
) (
  input  logic                          self_mode,
  input  logic [N_LINES-1:0]            cfg,
  input  logic [N_LINES-1:0]            v_i,
  input  logic [N_LINES-1:0][PAY_W-1:0] p_i,
  output logic [N_LINES-1:0]            v_o,
  output logic [N_LINES-1:0][PAY_W-1:0] p_o,
  output logic [N_LINES/2-1:0]          drop_o,
  output logic [N_LINES/2-1:0][SRC_W-1:0] drop_src_o
);
  localparam int HALF = N_LINES / 2;

  logic [N_LINES-1:0]            sv;
  logic [N_LINES-1:0][PAY_W-1:0] sp;

  omega_shuffle #(.N_LINES(N_LINES), .PAY_W(PAY_W)) u_shuf (
    .v_i(v_i), .p_i(p_i), .v_o(sv), .p_o(sp)
  );

  for (genvar e = 0; e < HALF; e++) begin : g_elem
    omega_switch #(.PAY_W(PAY_W)) u_sw (
      .self_mode (self_mode),
      .setting   (cfg[2*e +: 2]),
      .up_v      (sv[2*e]),
      .up_p      (sp[2*e]),
      .up_bit    (sp[2*e][STEER_AT]),
      .lo_v      (sv[2*e+1]),
      .lo_p      (sp[2*e+1]),
      .lo_bit    (sp[2*e+1][STEER_AT]),
      .o_up_v    (v_o[2*e]),
      .o_up_p    (p_o[2*e]),
      .o_lo_v    (v_o[2*e+1]),
      .o_lo_p    (p_o[2*e+1]),
      .lo_drop   (drop_o[e])
    );
    assign drop_src_o[e] = sp[2*e+1][SRC_W-1:0];
  end
endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 8,
  localparam int LG     = $clog2(N_PORTS),
  localparam int CFG_W  = LG * N_PORTS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      self_route,
  input  logic [N_PORTS-1:0]        in_valid,
  input  logic [N_PORTS*DATA_W-1:0] in_data,
  input  logic [N_PORTS*LG-1:0]     in_dest,
  input  logic [CFG_W-1:0]          sw_cfg,
  output logic [N_PORTS-1:0]        out_valid,
  output logic [N_PORTS*DATA_W-1:0] out_data,
  output logic [N_PORTS-1:0]        blocked
);
  localparam int HALF  = N_PORTS / 2;
  localparam int PAY_W = DATA_W + 2 * LG;   // {data, dest, src}

  logic [N_PORTS-1:0]            lv [0:LG];
  logic [N_PORTS-1:0][PAY_W-1:0] lp [0:LG];
  logic [HALF-1:0]               drp  [0:LG-1];
  logic [HALF-1:0][LG-1:0]       dsrc [0:LG-1];
  logic [N_PORTS-1:0]            blk_c;

  assign lv[0] = in_valid;
  for (genvar i = 0; i < N_PORTS; i++) begin : g_pack
    assign lp[0][i] = {in_data[i*DATA_W +: DATA_W], in_dest[i*LG +: LG], LG'(i)};
  end

  for (genvar s = 0; s < LG; s++) begin : g_stage
    omega_stage #(
      .N_LINES  (N_PORTS),
      .PAY_W    (PAY_W),
      .SRC_W    (LG),
      .STEER_AT (LG + LG - 1 - s)
    ) u_stage (
      .self_mode  (self_route),
      .cfg        (sw_cfg[s*N_PORTS +: N_PORTS]),
      .v_i        (lv[s]),
      .p_i        (lp[s]),
      .v_o        (lv[s+1]),
      .p_o        (lp[s+1]),
      .drop_o     (drp[s]),
      .drop_src_o (dsrc[s])
    );
  end

  always_comb begin
    blk_c = '0;
    for (int s = 0; s < LG; s++) begin
      for (int e = 0; e < HALF; e++) begin
        if (drp[s][e]) blk_c[dsrc[s][e]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      out_data  <= '0;
      blocked   <= '0;
    end else begin
      out_valid <= lv[LG];
      for (int i = 0; i < N_PORTS; i++) begin
        out_data[i*DATA_W +: DATA_W] <= lv[LG][i] ? lp[LG][i][PAY_W-1 -: DATA_W] : '0;
      end
      blocked <= self_route ? blk_c : '0;
    end
  end
endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      self_route,
  input logic [N_PORTS-1:0]        in_valid,
  input logic [N_PORTS*DATA_W-1:0] out_data,
  input logic [N_PORTS-1:0]        out_valid,
  input logic [N_PORTS-1:0]        blocked
);
  // R1: reset clears every output
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (out_valid == '0 && blocked == '0 && out_data == '0));

  // R7: explicit mode never flags a block
  a_r7_no_block_explicit: assert property (@(posedge clk) disable iff (rst)
    !self_route |=> (blocked == '0));

  // R4: only inputs that were valid can be flagged
  a_r4_flag_needs_valid: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((blocked & ~$past(in_valid)) == '0));

  // R3 and R4: in self-routing each valid word is delivered or flagged, never both or neither
  a_r3_words_conserved: assert property (@(posedge clk) disable iff (rst)
    self_route |=> ($countones(out_valid) + $countones(blocked) == $countones($past(in_valid))));

  // R9: idle inputs produce no output
  a_r9_idle_in_idle_out: assert property (@(posedge clk) disable iff (rst)
    (in_valid == '0) |=> (out_valid == '0));

  for (genvar i = 0; i < N_PORTS; i++) begin : g_zero
    // R9: an invalid output shows zero data
    a_r9_zero_data: assert property (@(posedge clk) disable iff (rst)
      !out_valid[i] |-> (out_data[i*DATA_W +: DATA_W] == '0));
  end
endmodule

bind omega_net omega_net_chk #(.N_PORTS(N_PORTS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .self_route(self_route), .in_valid(in_valid),
  .out_data(out_data), .out_valid(out_valid), .blocked(blocked)
);

// File: tb/tb_omega_net.sv
module tb_omega_net;
  localparam int N  = 8;
  localparam int W  = 8;
  localparam int LG = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              self_route = 1'b0;
  logic [N-1:0]      in_valid = '0;
  logic [N*W-1:0]    in_data = '0;
  logic [N*LG-1:0]   in_dest = '0;
  logic [LG*N-1:0]   sw_cfg = '0;
  logic [N-1:0]      out_valid;
  logic [N*W-1:0]    out_data;
  logic [N-1:0]      blocked;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [N-1:0]   exp_v;
  logic [N*W-1:0] exp_d;
  logic [N-1:0]   exp_b;
  string          exp_tag;

  omega_net #(.N_PORTS(N), .DATA_W(W)) dut (
    .clk(clk), .rst(rst), .self_route(self_route), .in_valid(in_valid),
    .in_data(in_data), .in_dest(in_dest), .sw_cfg(sw_cfg),
    .out_valid(out_valid), .out_data(out_data), .blocked(blocked)
  );

  always #10 clk = ~clk;   // 50 MHz

  // Behavioural reference: walks words through the stages with integer arrays
  task automatic model(input bit ms, input logic [N-1:0] iv, input logic [N*W-1:0] id,
                       input logic [N*LG-1:0] it, input logic [LG*N-1:0] cf);
    int v[N], d[N], t[N], s[N];
    int nv[N], nd[N], nt[N], ns[N];
    int ov[N], od[N], ot[N], os[N];
    exp_b = '0;
    for (int i = 0; i < N; i++) begin
      v[i] = iv[i]; d[i] = id[i*W +: W]; t[i] = it[i*LG +: LG]; s[i] = i;
    end
    for (int st = 0; st < LG; st++) begin
      for (int a = 0; a < N; a++) begin
        int r;
        r = ((a << 1) | (a >> (LG - 1))) & (N - 1);
        nv[r] = v[a]; nd[r] = d[a]; nt[r] = t[a]; ns[r] = s[a];
      end
      for (int i = 0; i < N; i++) begin
        ov[i] = 0; od[i] = 0; ot[i] = 0; os[i] = 0;
      end
      for (int e = 0; e < N / 2; e++) begin
        int u, l, bu, bl, c;
        u = 2 * e; l = 2 * e + 1;
        if (ms) begin
          bu = (nt[u] >> (LG - 1 - st)) & 1;
          bl = (nt[l] >> (LG - 1 - st)) & 1;
          if (nv[u] != 0) begin
            ov[u+bu] = 1; od[u+bu] = nd[u]; ot[u+bu] = nt[u]; os[u+bu] = ns[u];
          end
          if (nv[l] != 0) begin
            if (nv[u] != 0 && bu == bl) exp_b[ns[l]] = 1'b1;
            else begin
              ov[u+bl] = 1; od[u+bl] = nd[l]; ot[u+bl] = nt[l]; os[u+bl] = ns[l];
            end
          end
        end else begin
          c = cf[(st*(N/2)+e)*2 +: 2];
          case (c)
            0: begin
              ov[u] = nv[u]; od[u] = nd[u]; ov[l] = nv[l]; od[l] = nd[l];
            end
            1: begin
              ov[u] = nv[l]; od[u] = nd[l]; ov[l] = nv[u]; od[l] = nd[u];
            end
            2: begin
              ov[u] = nv[u]; od[u] = nd[u]; ov[l] = nv[u]; od[l] = nd[u];
            end
            default: begin
              ov[u] = nv[l]; od[u] = nd[l]; ov[l] = nv[l]; od[l] = nd[l];
            end
          endcase
        end
      end
      for (int i = 0; i < N; i++) begin
        v[i] = ov[i]; d[i] = od[i]; t[i] = ot[i]; s[i] = os[i];
      end
    end
    for (int i = 0; i < N; i++) begin
      exp_v[i] = (v[i] != 0);
      exp_d[i*W +: W] = (v[i] != 0) ? W'(d[i]) : '0;
    end
  endtask

  task automatic compare_outputs();
    compared++;
    if (out_valid !== exp_v || out_data !== exp_d || blocked !== exp_b) begin
      mismatched++;
      $display("FAIL %s: valid=%h data=%h blocked=%h expected valid=%h data=%h blocked=%h",
               exp_tag, out_valid, out_data, blocked, exp_v, exp_d, exp_b);
    end
  endtask

  task automatic check_val(input string tag, input logic [63:0] act, input logic [63:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Compare the last result, then drive a new pattern and predict it
  task automatic apply(input bit ms, input logic [N-1:0] iv, input logic [N*W-1:0] id,
                       input logic [N*LG-1:0] it, input logic [LG*N-1:0] cf, input string tag);
    @(negedge clk);
    compare_outputs();
    self_route = ms; in_valid = iv; in_data = id; in_dest = it; sw_cfg = cf;
    model(ms, iv, id, it, cf);
    exp_tag = tag;
  endtask

  function automatic logic [N*W-1:0] rand_data();
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = W'($urandom);
    return r;
  endfunction

  function automatic logic [N*LG-1:0] rand_perm();
    int p[N];
    logic [N*LG-1:0] r;
    for (int i = 0; i < N; i++) p[i] = i;
    for (int i = N - 1; i > 0; i--) begin
      int j, tmp;
      j = $urandom % (i + 1);
      tmp = p[i]; p[i] = p[j]; p[j] = tmp;
    end
    for (int i = 0; i < N; i++) r[i*LG +: LG] = LG'(p[i]);
    return r;
  endfunction

  function automatic logic [N*LG-1:0] ident_dest();
    logic [N*LG-1:0] r;
    for (int i = 0; i < N; i++) r[i*LG +: LG] = LG'(i);
    return r;
  endfunction

  function automatic logic [LG*N-1:0] uniform_cfg(input logic [1:0] c);
    logic [LG*N-1:0] r;
    for (int i = 0; i < LG * N / 2; i++) r[i*2 +: 2] = c;
    return r;
  endfunction

  initial begin
    logic [N*W-1:0] seq_data;
    exp_v = '0; exp_d = '0; exp_b = '0; exp_tag = "R1";
    for (int i = 0; i < N; i++) seq_data[i*W +: W] = W'(8'h10 + i);
    // R1: reset state with busy inputs present
    rst = 1'b1;
    in_valid = '1; in_data = rand_data(); self_route = 1'b1; in_dest = rand_perm();
    repeat (3) begin
      @(negedge clk);
      compare_outputs();
    end
    rst = 1'b0; in_valid = '0;
    model(1'b0, '0, '0, '0, '0);
    exp_tag = "R1";

    // R8: all straight keeps port order; R2 one-cycle latency via per-cycle compare
    apply(1'b0, '1, seq_data, rand_perm(), uniform_cfg(2'b00), "R8");
    apply(1'b0, '0, '0, '0, '0, "R9");
    check_val("R8 straight data", 64'(out_data), 64'(seq_data));
    check_val("R8 straight valid", 64'(out_valid), 64'hFF);

    // R5 and R6: uniform element settings
    apply(1'b0, '1, rand_data(), '0, uniform_cfg(2'b01), "R5");
    apply(1'b0, '1, rand_data(), rand_perm(), uniform_cfg(2'b10), "R6");
    apply(1'b0, '1, rand_data(), '0, uniform_cfg(2'b11), "R6");
    apply(1'b0, 8'h5A, rand_data(), '0, uniform_cfg(2'b10), "R6");

    // R4: ports 0 and 4 both aim at port 0 and meet in the first stage
    apply(1'b1, 8'h11, {24'h0, 8'h3C, 24'h0, 8'hA5}, '0, '0, "R4");
    apply(1'b0, '0, '0, '0, '0, "R9");
    check_val("R4 winner valid", 64'(out_valid), 64'h01);
    check_val("R4 winner data", 64'(out_data[W-1:0]), 64'hA5);
    check_val("R4 loser flagged", 64'(blocked), 64'h10);

    // R9: invalid words with junk payloads leave nothing behind
    apply(1'b1, '0, rand_data(), '0, '0, "R9");
    apply(1'b0, '0, '0, '0, '0, "R9");
    check_val("R9 idle valid", 64'(out_valid), 64'h0);
    check_val("R9 idle data", 64'(out_data), 64'h0);
    check_val("R9 idle blocked", 64'(blocked), 64'h0);

    // R3: identity destinations route cleanly
    apply(1'b1, '1, seq_data, ident_dest(), '0, "R3");
    apply(1'b0, '0, '0, '0, '0, "R9");
    check_val("R3 identity data", 64'(out_data), 64'(seq_data));
    check_val("R3 identity blocked", 64'(blocked), 64'h0);

    // R3: random full permutations, partial valid masks
    for (int k = 0; k < 60; k++)
      apply(1'b1, (k % 3 == 0) ? N'($urandom) : '1, rand_data(), rand_perm(), '0, "R3");
    // R4: random destinations with duplicates
    for (int k = 0; k < 60; k++)
      apply(1'b1, N'($urandom) | 8'h81, rand_data(), (N*LG)'($urandom), '0, "R4");
    // R5 R6 R7: random explicit settings with random destinations
    for (int k = 0; k < 60; k++)
      apply(1'b0, N'($urandom), rand_data(), (N*LG)'($urandom), (LG*N)'($urandom), "R7");
    // R10: random settings present in self-routing mode
    for (int k = 0; k < 40; k++)
      apply(1'b1, N'($urandom), rand_data(), rand_perm(), (LG*N)'($urandom), "R10");
    apply(1'b0, '0, '0, '0, '0, "R9");
    @(negedge clk);
    compare_outputs();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule